// File: doc/BRIEF.md
# Post-Divider with Stepped Power-Down

This block takes a fast oscillator clock and produces an output clock at a programmable fraction of it. A 2-bit select picks a division ratio of 1, 2, 4 or 8, and the output keeps a 50% duty cycle at every ratio. At ratio 1 the output is the oscillator clock itself. At the other ratios it comes from a half-period counter.

A power-down request lowers the output frequency by an extra factor of 16. The change is not made in one jump. A small step counter runs on a slower reference clock, and each reference edge moves it by one place. Each place doubles or halves the extra division. A held request therefore ramps the output down in four binary steps. A release ramps it back up to the programmed rate in four steps. The power-down input is sampled on the reference clock.

The step count enters the oscillator domain in Gray code through a synchronizer. A new total ratio is applied only at a rising edge of the output, so no shortened high or low phase is ever produced. The select input is treated as quasi-static. It is read only at those same output rising edges.

Top module: `pdiv_stepdown`

## Requirements
- R1: With the step count at 0, the select code sets the output period in oscillator cycles: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8.
- R2: The output high time equals half its period at every total ratio, from 1 to 128.
- R3: While power-down is high, each rising reference edge raises the step count by one. Each step doubles the period, so after four edges the period is 16 times the programmed value.
- R4: Once the step count is 4, further reference edges with power-down high leave the period at 16 times the programmed value.
- R5: While power-down is low, each rising reference edge lowers the step count by one and halves the period. Four edges bring the period back to the programmed value.
- R6: A change of total ratio takes effect only at an output rising edge. A high or low phase already in progress completes at the old half-period length.
- R7: While reset is low, the output is held low. After reset the step count is 0, and the output runs at the programmed ratio regardless of the power-down level until reference edges occur.
- R8: Without rising reference edges, a change of the power-down level does not change the output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vcoClk | input | 1 | Fast oscillator clock to be divided |
| refClk | input | 1 | Slow reference clock that paces the power-down steps |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| divSel | input | 2 | Division select code (00=÷1, 01=÷2, 10=÷4, 11=÷8) |
| pwrDown | input | 1 | Power-down request, sampled on refClk |
| clkOut | output | 1 | Divided output clock, 50% duty cycle |

## Verification
The hardest case to reach from the ports is a ratio change that arrives part way through an output phase. If the design were wrong, this is where a runt pulse would appear. The bench makes the reference clock a pulsed signal under its own control, so it can stop the step counter at any place and step it one edge at a time. It then measures every period in that state. For the runt case it waits for an output rising edge at ratio 8 and changes the select 30 ns later. It then times the high and low phases still in progress before it measures the new period.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  localparam int SEL_W    = 2;
  localparam int STEP_MAX = 4;
  localparam int STEP_W   = $clog2(STEP_MAX + 1);
  localparam int EXP_MAX  = (2 ** SEL_W - 1) + STEP_MAX;
  localparam int EXP_W    = $clog2(EXP_MAX + 1);
  localparam int CNT_W    = (EXP_MAX > 1) ? EXP_MAX - 1 : 1;

  typedef struct packed {
    logic             live;
    logic [EXP_W-1:0] tgtExp;
  } ctrlStrb_t;
endpackage

// File: rtl/pdiv_ctrl.sv
module pdiv_ctrl
  import pdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             refClk,
  input  logic             vcoClk,
  input  logic             rstN,
  input  logic             pwrDown,
  input  logic [SEL_W-1:0] divSel,
  output ctrlStrb_t        strb
);
  localparam logic [STEP_W-1:0] STEP_TOP = STEP_W'(STEP_MAX);

  logic [STEP_W-1:0] stepRef, stepNext, grayRef, stepVco;
  logic [STEP_W-1:0] syncQ [SYNC_STAGES];
  logic              liveQ;

  function automatic logic [STEP_W-1:0] grayToBin(input logic [STEP_W-1:0] g);
    logic [STEP_W-1:0] b;
    b[STEP_W-1] = g[STEP_W-1];
    for (int i = STEP_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_comb begin
    stepNext = stepRef;
    if (pwrDown && stepRef != STEP_TOP)  stepNext = stepRef + 1'b1;
    else if (!pwrDown && stepRef != '0)  stepNext = stepRef - 1'b1;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      stepRef <= '0;
      grayRef <= '0;
    end else begin
      stepRef <= stepNext;
      grayRef <= stepNext ^ (stepNext >> 1);
    end
  end

  always_ff @(posedge vcoClk or negedge rstN) begin
    if (!rstN) begin
      syncQ[0] <= '0;
      liveQ    <= 1'b0;
    end else begin
      syncQ[0] <= grayRef;
      liveQ    <= 1'b1;
    end
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge vcoClk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign stepVco     = grayToBin(syncQ[SYNC_STAGES-1]);
  assign strb.tgtExp = EXP_W'(divSel) + EXP_W'(stepVco);
  assign strb.live   = liveQ;

  // R4
  step_max_chk: assert property (@(posedge refClk) disable iff (!rstN)
    stepRef <= STEP_TOP);

  // R3
  step_rise_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (pwrDown && stepRef != STEP_TOP) |=> (stepRef == $past(stepRef) + 1'b1));

  // R5
  step_fall_chk: assert property (@(posedge refClk) disable iff (!rstN)
    (!pwrDown && stepRef != '0) |=> (stepRef == $past(stepRef) - 1'b1));
endmodule

// File: rtl/pdiv_dp.sv
module pdiv_dp
  import pdiv_pkg::*;
(
  input  logic      vcoClk,
  input  logic      rstN,
  input  ctrlStrb_t strb,
  output logic      clkOut
);
  logic [EXP_W-1:0] appExp;
  logic [CNT_W-1:0] cnt;
  logic             divQ;
  logic             boundary;

  function automatic logic [CNT_W-1:0] halfM1(input logic [EXP_W-1:0] e);
    return (CNT_W'(1) << (e - 1'b1)) - 1'b1;
  endfunction

  assign boundary = (appExp == '0) || (!divQ && cnt == '0);

  always_ff @(posedge vcoClk or negedge rstN) begin
    if (!rstN) begin
      appExp <= '0;
      divQ   <= 1'b0;
      cnt    <= '0;
    end else if (boundary) begin
      appExp <= strb.tgtExp;
      if (strb.tgtExp == '0) begin
        divQ <= 1'b0;
        cnt  <= '0;
      end else begin
        divQ <= 1'b1;
        cnt  <= halfM1(strb.tgtExp);
      end
    end else if (cnt == '0) begin
      divQ <= ~divQ;
      cnt  <= halfM1(appExp);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign clkOut = strb.live && ((appExp == '0) ? vcoClk : divQ);

  // R6
  half_len_chk: assert property (@(posedge vcoClk) disable iff (!rstN)
    (appExp != '0) |-> (cnt <= halfM1(appExp)));

  // R6
  exp_hold_chk: assert property (@(posedge vcoClk) disable iff (!rstN)
    divQ |=> $stable(appExp));

  // R7
  always_comb begin
    if (!strb.live) rst_low_chk: assert (!clkOut);
  end
endmodule

// File: rtl/pdiv_stepdown.sv
module pdiv_stepdown
  import pdiv_pkg::*;
(
  input  logic             vcoClk,
  input  logic             refClk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] divSel,
  input  logic             pwrDown,
  output logic             clkOut
);
  ctrlStrb_t strb;

  pdiv_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .refClk (refClk),
    .vcoClk (vcoClk),
    .rstN   (rstN),
    .pwrDown(pwrDown),
    .divSel (divSel),
    .strb   (strb)
  );

  pdiv_dp u_dp (
    .vcoClk(vcoClk),
    .rstN  (rstN),
    .strb  (strb),
    .clkOut(clkOut)
  );
endmodule

// File: tb/pdiv_stepdown_bench.sv
module pdiv_stepdown_bench;
  logic       vcoClk = 1'b0;
  logic       refClk = 1'b0;
  logic       rstN   = 1'b0;
  logic [1:0] divSel = 2'b00;
  logic       pwrDown = 1'b0;
  logic       clkOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  pdiv_stepdown u_pdiv_stepdown (
    .vcoClk (vcoClk),
    .refClk (refClk),
    .rstN   (rstN),
    .divSel (divSel),
    .pwrDown(pwrDown),
    .clkOut (clkOut)
  );

  always #10 vcoClk = ~vcoClk;

  // {select code, reference edges with power-down high, expected period in oscillator cycles}
  localparam int VEC [8][3] = '{
    '{0, 0, 1}, '{1, 0, 2}, '{2, 0, 4}, '{3, 0, 8},
    '{0, 1, 2}, '{1, 2, 8}, '{2, 3, 32}, '{3, 6, 128}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic refPulse();
    #37 refClk = 1'b1;
    #37 refClk = 1'b0;
  endtask

  task automatic measure(output longint perNs, output longint highNs);
    time t0, t1, t2;
    repeat (2) @(posedge clkOut);
    @(posedge clkOut) t0 = $time;
    @(negedge clkOut) t1 = $time;
    @(posedge clkOut) t2 = $time;
    perNs  = longint'(t2 - t0);
    highNs = longint'(t1 - t0);
  endtask

  task automatic checkRatio(input string tag, input int ratio);
    longint per, hi;
    measure(per, hi);
    chk(per == 20 * ratio, tag, per, 20 * ratio);
    chk(2 * hi == per, "R2 duty", 2 * hi, per);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint per, hi;
    time t0, t1, t2;

    // R7: output low during reset, with the oscillator running
    refPulse();
    repeat (5) begin
      @(negedge vcoClk);
      chk(clkOut == 1'b0, "R7 reset low", clkOut, 0);
    end
    #3 rstN = 1'b1;

    // R1 R2 R3 R4: table of select codes and power-down step counts
    for (int v = 0; v < 8; v++) begin
      pwrDown = 1'b0;
      repeat (5) refPulse();
      divSel  = VEC[v][0][1:0];
      pwrDown = 1'b1;
      for (int k = 0; k < VEC[v][1]; k++) refPulse();
      checkRatio((VEC[v][1] > 4) ? "R4 saturate" : (VEC[v][1] > 0) ? "R3 step down" : "R1 ratio",
                 VEC[v][2]);
    end

    // R5: release in four steps from ÷16 extra at select 00
    divSel = 2'b00;
    pwrDown = 1'b1;
    repeat (4) refPulse();
    checkRatio("R3 full 16x", 16);
    pwrDown = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      refPulse();
      checkRatio("R5 step up", 16 >> i);
    end

    // R8: power-down level change with no reference edges
    divSel = 2'b10;
    checkRatio("R1 ratio 4", 4);
    pwrDown = 1'b1;
    checkRatio("R8 no ref edge", 4);
    pwrDown = 1'b0;

    // R6: select change in the middle of a high phase
    divSel = 2'b11;
    checkRatio("R1 ratio 8", 8);
    @(posedge clkOut) t0 = $time;
    #30 divSel = 2'b01;
    @(negedge clkOut) t1 = $time;
    @(posedge clkOut) t2 = $time;
    chk((t1 - t0) == 80, "R6 old high kept", longint'(t1 - t0), 80);
    chk((t2 - t1) == 80, "R6 old low kept", longint'(t2 - t1), 80);
    checkRatio("R6 new ratio", 2);

    // R7: reset in a stepped state returns to programmed ratio
    pwrDown = 1'b1;
    repeat (3) refPulse();
    checkRatio("R3 stepped", 16);
    @(negedge vcoClk) rstN = 1'b0;
    refPulse();
    @(negedge vcoClk);
    chk(clkOut == 1'b0, "R7 reset low again", clkOut, 0);
    #3 rstN = 1'b1;
    checkRatio("R7 step cleared", 2);
    pwrDown = 1'b0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule